// File: doc/BRIEF.md
# Protected Translation Lookaside Buffer

This block caches a handful of page translations and checks access rights on each use. A lookup presents a virtual address and an access kind. The block searches every entry at once. When a valid entry matches the page and grants the requested right, it returns the physical address: the frame number with the 10-bit page offset below it. When no valid entry matches, it reports a miss. When an entry matches but does not grant the right, it reports a protection fault. A write that is allowed marks its entry as modified.

After a miss, a separate port writes a new translation into the buffer. The entry is chosen from the current contents. A flush input drops every translation in one cycle. Walking the page tables and handling faults are left to the logic around the block.

Top module: `tlb_guard`

## Requirements
- R1: After reset every entry is invalid, no response is flagged, and the replacement pointer is at entry 0.
- R2: A lookup raised in one cycle is answered in the next cycle with `respValid` high, and only then. On a hit `respHit` is high and `respPaddr` is the entry's frame number above the low 10 address bits, which pass through unchanged.
- R3: A lookup that finds no valid entry with the same virtual page number raises `respMiss`, with `respPaddr` and `respDirty` zero.
- R4: Access kind 0 is a read, 1 a write, 2 an execute, and 3 is never granted. The right bits are: bit 0 read, bit 1 write, bit 2 execute. A matching entry without the right raises `respFault`, drives `respPaddr` to zero, and leaves the entry unchanged.
- R5: A granted write sets the entry's dirty bit. `respDirty` on a hit shows the dirty bit as it stood before that lookup. A refill loads the entry with its dirty bit clear.
- R6: Any virtual page may sit in any entry, and every entry is searched on each lookup.
- R7: A refill of a page that is not present goes to the lowest-numbered invalid entry, if there is one.
- R8: When all entries are valid, a refill of a page that is not present replaces the entry under a round-robin pointer. The pointer then advances by one and wraps after the last entry.
- R9: A refill of a page that is already present overwrites that same entry and leaves the pointer unchanged, so a page never matches twice.
- R10: Flush clears every valid bit in one cycle. A refill in the same cycle is dropped. A lookup in the same cycle is answered from the contents held before the flush.
- R11: A lookup in the same cycle as a refill is answered from the contents held before the refill. A refill to the entry that the same lookup writes to leaves the dirty bit clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Drop every translation |
| lookupValid | input | 1 | Lookup request |
| lookupVaddr | input | VA_W (32) | Virtual address to translate |
| lookupKind | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 none |
| refillValid | input | 1 | Load a translation |
| refillVpn | input | VA_W-OFF_W (22) | Virtual page number to load |
| refillPfn | input | PFN_W (20) | Frame number to load |
| refillPerm | input | 3 | Rights to load: bit 0 read, bit 1 write, bit 2 execute |
| respValid | output | 1 | Response present |
| respHit | output | 1 | Translation granted |
| respMiss | output | 1 | No valid entry for the page |
| respFault | output | 1 | Entry found but the right is missing |
| respDirty | output | 1 | Dirty bit before this lookup (hits only) |
| respPaddr | output | PFN_W+OFF_W (30) | Physical address on a hit, zero otherwise |

## Verification
Lookups use all four access kinds against entries that grant one right, two rights or all three. This separates the right-decoding paths from one another and from the miss path. Offsets at both ends of the page, including all-ones page and frame numbers, show that no address bit is dropped or moved. Refills first into an empty buffer, then into a full one, then over a page already present, separate lowest-free selection, pointer rotation and in-place overwrite. Refill and flush are placed in the same cycle as lookups, and as each other, to pin down which contents a same-cycle lookup sees.

// File: rtl/tlb_guard_pkg.sv
package tlb_guard_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_NONE  = 2'd3
  } accKind_e;

  // strobes from control to the entry store
  typedef struct packed {
    logic dirtySet;
    logic refillWr;
    logic flushAll;
  } tlbStrobe_t;

endpackage

// File: rtl/tlb_guard_store.sv
module tlb_guard_store
  import tlb_guard_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 22,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  tlbStrobe_t         stb,
  input  logic [IDX_W-1:0]   dirtyIdx,
  input  logic [IDX_W-1:0]   refillIdx,
  input  logic [VPN_W-1:0]   refillVpn,
  input  logic [PFN_W-1:0]   refillPfn,
  input  logic [2:0]         refillPerm,
  input  logic [VPN_W-1:0]   lookupVpn,
  output logic [ENTRIES-1:0] lkHitVec,
  output logic [PFN_W-1:0]   lkPfn,
  output logic [2:0]         lkPerm,
  output logic               lkDirty,
  output logic [ENTRIES-1:0] rfHitVec,
  output logic [ENTRIES-1:0] validVec
);

  logic [ENTRIES-1:0] validQ;
  logic [ENTRIES-1:0] dirtyQ;
  logic [VPN_W-1:0]   vpnQ  [ENTRIES];
  logic [PFN_W-1:0]   pfnQ  [ENTRIES];
  logic [2:0]         permQ [ENTRIES];

  assign validVec = validQ;

  // parallel compare, one comparator pair per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign lkHitVec[g] = validQ[g] && (vpnQ[g] == lookupVpn);
    assign rfHitVec[g] = validQ[g] && (vpnQ[g] == refillVpn);
  end

  // AND-OR read mux; at most one entry matches
  always_comb begin
    lkPfn   = '0;
    lkPerm  = '0;
    lkDirty = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (lkHitVec[i]) begin
        lkPfn   = lkPfn | pfnQ[i];
        lkPerm  = lkPerm | permQ[i];
        lkDirty = lkDirty | dirtyQ[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        vpnQ[i]  <= '0;
        pfnQ[i]  <= '0;
        permQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (stb.flushAll) begin
          validQ[i] <= 1'b0;
        end else if (stb.refillWr && refillIdx == IDX_W'(i)) begin
          validQ[i] <= 1'b1;
          vpnQ[i]   <= refillVpn;
          pfnQ[i]   <= refillPfn;
          permQ[i]  <= refillPerm;
        end
        if (stb.refillWr && refillIdx == IDX_W'(i)) begin
          dirtyQ[i] <= 1'b0;
        end else if (stb.dirtySet && dirtyIdx == IDX_W'(i)) begin
          dirtyQ[i] <= 1'b1;
        end
      end
    end
  end

  // R9
  uniq_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkHitVec));

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.flushAll |=> (validQ == '0));

  // R5
  dirty_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.dirtySet && !(stb.refillWr && refillIdx == dirtyIdx)) |=> dirtyQ[$past(dirtyIdx)]);

  // R7
  refill_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.refillWr |=> (validQ[$past(refillIdx)] && !dirtyQ[$past(refillIdx)]));

endmodule

// File: rtl/tlb_guard_ctrl.sv
module tlb_guard_ctrl
  import tlb_guard_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int PFN_W   = 20,
  parameter int OFF_W   = 10,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PA_W   = PFN_W + OFF_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               flush,
  input  logic               lookupValid,
  input  logic [1:0]         lookupKind,
  input  logic [OFF_W-1:0]   lookupOff,
  input  logic               refillValid,
  input  logic [ENTRIES-1:0] lkHitVec,
  input  logic [PFN_W-1:0]   lkPfn,
  input  logic [2:0]         lkPerm,
  input  logic               lkDirty,
  input  logic [ENTRIES-1:0] rfHitVec,
  input  logic [ENTRIES-1:0] validVec,
  output tlbStrobe_t         stb,
  output logic [IDX_W-1:0]   dirtyIdx,
  output logic [IDX_W-1:0]   refillIdx,
  output logic               respValid,
  output logic               respHit,
  output logic               respMiss,
  output logic               respFault,
  output logic               respDirty,
  output logic [PA_W-1:0]    respPaddr
);

  logic [IDX_W-1:0] rrPtr;
  logic [IDX_W-1:0] hitIdx, rfIdx, freeIdx;
  logic             anyHit, rfAny, freeAny, granted, usePtr;
  accKind_e         kind;

  assign kind = accKind_e'(lookupKind);

  always_comb begin
    hitIdx  = '0;
    rfIdx   = '0;
    freeIdx = '0;
    freeAny = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkHitVec[i]) hitIdx = IDX_W'(i);
      if (rfHitVec[i]) rfIdx = IDX_W'(i);
      if (!validVec[i]) begin
        freeIdx = IDX_W'(i);
        freeAny = 1'b1;
      end
    end
  end

  assign anyHit = |lkHitVec;
  assign rfAny  = |rfHitVec;

  always_comb begin
    unique case (kind)
      ACC_READ:  granted = lkPerm[0];
      ACC_WRITE: granted = lkPerm[1];
      ACC_EXEC:  granted = lkPerm[2];
      default:   granted = 1'b0;
    endcase
  end

  // victim: matching page, then lowest free slot, then rotating pointer
  assign usePtr    = !rfAny && !freeAny;
  assign refillIdx = rfAny ? rfIdx : (freeAny ? freeIdx : rrPtr);
  assign dirtyIdx  = hitIdx;

  assign stb.flushAll = flush;
  assign stb.refillWr = refillValid && !flush;
  assign stb.dirtySet = lookupValid && anyHit && granted && (kind == ACC_WRITE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr <= '0;
    end else if (stb.refillWr && usePtr) begin
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respHit   <= 1'b0;
      respMiss  <= 1'b0;
      respFault <= 1'b0;
      respDirty <= 1'b0;
      respPaddr <= '0;
    end else begin
      respValid <= lookupValid;
      respHit   <= lookupValid && anyHit && granted;
      respMiss  <= lookupValid && !anyHit;
      respFault <= lookupValid && anyHit && !granted;
      respDirty <= lookupValid && anyHit && granted && lkDirty;
      respPaddr <= (lookupValid && anyHit && granted) ? {lkPfn, lookupOff} : '0;
    end
  end

  // R2
  resp_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> respValid);

  // R2
  resp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !respValid);

  // R4
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($countones({respHit, respMiss, respFault}) == 1));

  // R3
  no_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respMiss || respFault) |-> (respPaddr == '0 && !respDirty));

  // R8
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.refillWr && usePtr) |=> (rrPtr != $past(rrPtr)));

endmodule

// File: rtl/tlb_guard.sv
module tlb_guard
  import tlb_guard_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int VA_W    = 32,
  parameter int OFF_W   = 10,
  parameter int PFN_W   = 20,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PA_W   = PFN_W + OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             flush,
  input  logic             lookupValid,
  input  logic [VA_W-1:0]  lookupVaddr,
  input  logic [1:0]       lookupKind,
  input  logic             refillValid,
  input  logic [VPN_W-1:0] refillVpn,
  input  logic [PFN_W-1:0] refillPfn,
  input  logic [2:0]       refillPerm,
  output logic             respValid,
  output logic             respHit,
  output logic             respMiss,
  output logic             respFault,
  output logic             respDirty,
  output logic [PA_W-1:0]  respPaddr
);

  tlbStrobe_t         stb;
  logic [IDX_W-1:0]   dirtyIdx, refillIdx;
  logic [ENTRIES-1:0] lkHitVec, rfHitVec, validVec;
  logic [PFN_W-1:0]   lkPfn;
  logic [2:0]         lkPerm;
  logic               lkDirty;

  tlb_guard_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .dirtyIdx   (dirtyIdx),
    .refillIdx  (refillIdx),
    .refillVpn  (refillVpn),
    .refillPfn  (refillPfn),
    .refillPerm (refillPerm),
    .lookupVpn  (lookupVaddr[VA_W-1:OFF_W]),
    .lkHitVec   (lkHitVec),
    .lkPfn      (lkPfn),
    .lkPerm     (lkPerm),
    .lkDirty    (lkDirty),
    .rfHitVec   (rfHitVec),
    .validVec   (validVec)
  );

  tlb_guard_ctrl #(.ENTRIES(ENTRIES), .PFN_W(PFN_W), .OFF_W(OFF_W)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .flush       (flush),
    .lookupValid (lookupValid),
    .lookupKind  (lookupKind),
    .lookupOff   (lookupVaddr[OFF_W-1:0]),
    .refillValid (refillValid),
    .lkHitVec    (lkHitVec),
    .lkPfn       (lkPfn),
    .lkPerm      (lkPerm),
    .lkDirty     (lkDirty),
    .rfHitVec    (rfHitVec),
    .validVec    (validVec),
    .stb         (stb),
    .dirtyIdx    (dirtyIdx),
    .refillIdx   (refillIdx),
    .respValid   (respValid),
    .respHit     (respHit),
    .respMiss    (respMiss),
    .respFault   (respFault),
    .respDirty   (respDirty),
    .respPaddr   (respPaddr)
  );

endmodule

// File: tb/tb_tlb_guard.sv
module tb_tlb_guard;

  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        flush = 1'b0;
  logic        lookupValid = 1'b0;
  logic [31:0] lookupVaddr = '0;
  logic [1:0]  lookupKind = '0;
  logic        refillValid = 1'b0;
  logic [21:0] refillVpn = '0;
  logic [19:0] refillPfn = '0;
  logic [2:0]  refillPerm = '0;
  logic        respValid, respHit, respMiss, respFault, respDirty;
  logic [29:0] respPaddr;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string phaseTag = "R1";

  // behavioural model state
  bit          mV     [N];
  logic [21:0] mVpn   [N];
  logic [19:0] mPfn   [N];
  logic [2:0]  mPerm  [N];
  bit          mDirty [N];
  int          mPtr = 0;

  tlb_guard dut (
    .clk(clk), .rstN(rstN), .flush(flush),
    .lookupValid(lookupValid), .lookupVaddr(lookupVaddr), .lookupKind(lookupKind),
    .refillValid(refillValid), .refillVpn(refillVpn), .refillPfn(refillPfn),
    .refillPerm(refillPerm),
    .respValid(respValid), .respHit(respHit), .respMiss(respMiss),
    .respFault(respFault), .respDirty(respDirty), .respPaddr(respPaddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s (%s) %s: got %0h expected %0h", req, phaseTag, what, got, exp);
    end
  endtask

  task automatic cyc(input bit fl, input bit lk, input logic [21:0] vpn, input logic [9:0] off,
                     input logic [1:0] ty, input bit rf, input logic [21:0] rv,
                     input logic [19:0] rp, input logic [2:0] rperm);
    bit eH, eM, eF, eD, ok;
    logic [29:0] eP;
    int hi, setD, ri;
    flush = fl; lookupValid = lk; lookupVaddr = {vpn, off}; lookupKind = ty;
    refillValid = rf; refillVpn = rv; refillPfn = rp; refillPerm = rperm;
    eH = 0; eM = 0; eF = 0; eD = 0; eP = '0; hi = -1; setD = -1;
    for (int i = 0; i < N; i++) if (mV[i] && mVpn[i] == vpn) hi = i;
    if (lk) begin
      if (hi < 0) eM = 1;
      else begin
        ok = (ty == 2'd0 && mPerm[hi][0]) || (ty == 2'd1 && mPerm[hi][1]) ||
             (ty == 2'd2 && mPerm[hi][2]);
        if (!ok) eF = 1;
        else begin
          eH = 1; eP = {mPfn[hi], off}; eD = mDirty[hi];
          if (ty == 2'd1) setD = hi;
        end
      end
    end
    if (setD >= 0) mDirty[setD] = 1;
    if (fl) begin
      for (int i = 0; i < N; i++) mV[i] = 0;
    end else if (rf) begin
      ri = -1;
      for (int i = 0; i < N; i++) if (mV[i] && mVpn[i] == rv) ri = i;
      if (ri < 0) for (int i = N - 1; i >= 0; i--) if (!mV[i]) ri = i;
      if (ri < 0) begin ri = mPtr; mPtr = (mPtr + 1) % N; end
      mV[ri] = 1; mVpn[ri] = rv; mPfn[ri] = rp; mPerm[ri] = rperm; mDirty[ri] = 0;
    end
    @(posedge clk); #1;
    check("R2", "respValid", 32'(respValid), 32'(lk));
    check("R2", "respHit", 32'(respHit), 32'(eH));
    check("R3", "respMiss", 32'(respMiss), 32'(eM));
    check("R4", "respFault", 32'(respFault), 32'(eF));
    check("R5", "respDirty", 32'(respDirty), 32'(eD));
    check("R2", "respPaddr", 32'(respPaddr), 32'(eP));
  endtask

  task automatic look(input logic [21:0] vpn, input logic [9:0] off, input logic [1:0] ty);
    cyc(0, 1, vpn, off, ty, 0, '0, '0, '0);
  endtask

  task automatic fill(input logic [21:0] rv, input logic [19:0] rp, input logic [2:0] rperm);
    cyc(0, 0, '0, '0, '0, 1, rv, rp, rperm);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin mV[i] = 0; mDirty[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: outputs idle during reset
    check("R1", "reset respValid", 32'(respValid), 0);
    check("R1", "reset respPaddr", 32'(respPaddr), 0);
    rstN = 1'b1;
    phaseTag = "R1";
    look(22'h100, 10'h004, 2'd0);          // empty buffer misses
    look(22'h000, 10'h000, 2'd0);

    phaseTag = "R7";                        // fill empty slots in order
    fill(22'h100, 20'h0A000, 3'b001);
    fill(22'h200, 20'h0B000, 3'b011);
    fill(22'h300, 20'h0C000, 3'b100);
    fill(22'h3FFFFF, 20'hFFFFF, 3'b111);

    phaseTag = "R6";                        // every slot is reachable
    look(22'h100, 10'h3FF, 2'd0);
    look(22'h3FFFFF, 10'h000, 2'd0);
    look(22'h300, 10'h155, 2'd2);
    look(22'h200, 10'h2AA, 2'd0);
    look(22'h3FFFFF, 10'h3FF, 2'd2);

    phaseTag = "R4";                        // missing rights fault
    look(22'h100, 10'h010, 2'd1);
    look(22'h300, 10'h010, 2'd0);
    look(22'h200, 10'h010, 2'd2);
    look(22'h3FFFFF, 10'h010, 2'd3);
    look(22'h100, 10'h020, 2'd0);           // faulted write left dirty clear

    phaseTag = "R5";                        // granted write marks dirty
    look(22'h200, 10'h001, 2'd1);
    look(22'h200, 10'h002, 2'd1);
    look(22'h200, 10'h003, 2'd0);

    phaseTag = "R8";                        // full: pointer rotates from 0
    fill(22'h400, 20'h0E000, 3'b011);
    look(22'h100, 10'h000, 2'd0);
    look(22'h400, 10'h0F0, 2'd1);
    fill(22'h500, 20'h0F000, 3'b001);
    look(22'h200, 10'h000, 2'd0);
    look(22'h500, 10'h001, 2'd0);

    phaseTag = "R9";                        // refill of present page overwrites
    fill(22'h300, 20'h0D000, 3'b111);
    look(22'h300, 10'h033, 2'd1);
    fill(22'h600, 20'h01234, 3'b111);
    look(22'h300, 10'h033, 2'd0);
    look(22'h3FFFFF, 10'h001, 2'd0);
    look(22'h600, 10'h001, 2'd0);

    phaseTag = "R11";                       // same-cycle refill not visible
    cyc(0, 1, 22'h700, 10'h005, 2'd0, 1, 22'h700, 20'h07777, 3'b001);
    look(22'h700, 10'h005, 2'd0);
    look(22'h400, 10'h001, 2'd1);           // sets dirty on page 400
    cyc(0, 1, 22'h400, 10'h002, 2'd1, 1, 22'h400, 20'h04444, 3'b011);
    look(22'h400, 10'h003, 2'd0);           // refill cleared dirty

    phaseTag = "R10";                       // flush
    cyc(1, 1, 22'h700, 10'h009, 2'd0, 0, '0, '0, '0);
    look(22'h700, 10'h009, 2'd0);
    cyc(1, 0, '0, '0, '0, 1, 22'h800, 20'h08888, 3'b111);
    look(22'h800, 10'h000, 2'd0);

    phaseTag = "R7";                        // after flush, lowest free slot
    fill(22'h900, 20'h09999, 3'b101);
    look(22'h900, 10'h0AB, 2'd2);
    look(22'h900, 10'h0AB, 2'd1);

    cyc(0, 0, '0, '0, '0, 0, '0, '0, '0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule